// File: doc/BRIEF.md
# Thruster Charge-and-Fire Controller

This controller runs inside a pulsed-thruster power unit. Three active-high control lines reach it, already synchronised to the system clock: a fire line, a serial clock line and a serial data line. Raising the fire line opens a selection frame. While fire stays high, each rising edge of the serial clock shifts in one select bit, and there is one bit per spark plug. When fire falls, the controller checks the frame. A good frame starts a charge cycle: the controller pulls an active-low busy output low and drives the per-capacitor charge enables. A bad frame is dropped with an error flag.

The charge cycle ends in one of two ways. Either an external comparator reports that the capacitor voltage has been reached, or a watchdog expires. The controller then releases busy, waits a fixed hold-off, and pulses the selected spark-plug enables for a set number of cycles. All analog parts (flyback supply, comparator, triac drivers, optocouplers) are outside the block and appear only as digital pins.

The state machine has five states:
- IDLE waits for a frame.
- FRAME collects bits.
- CHARGE holds busy low.
- HOLDOFF waits the post-charge delay.
- FIRE drives the plug pulse.

The transitions between them are:
- start (IDLE→FRAME, on the fire rise).
- accept (FRAME→CHARGE, fire fall with a valid frame).
- abort (FRAME→IDLE, fire fall with an invalid frame).
- charged (CHARGE→HOLDOFF, charge-done or watchdog).
- spark (HOLDOFF→FIRE, delay elapsed).
- done (FIRE→IDLE, pulse elapsed).

Top module: `thr_fire_ctl`

## Requirements
- R1: After reset, busy_n_o is high, plug_en_o and cap_en_o are all zero, and sel_err_o is low.
- R2: A frame opens only on a rising edge of fire_i while IDLE. Data is captured only at rising edges of sclk_i inside an open frame. Serial clock edges outside a frame are ignored.
- R3: The mapping from pulses to plugs is reversed. Pulse p (1..N_PLUGS) selects plug_en_o bit N_PLUGS−p. Bit 2k is plug A and bit 2k+1 is plug B of assembly k+1. cap_en_o bit k is the OR of those two plug bits. With 4 plugs, pulses 1..4 select bits 3, 2, 1, 0.
- R4: A falling edge of fire_i on a valid frame drives busy_n_o low from the following cycle. cap_en_o is driven for the whole charge, hold-off and fire phases.
- R5: When chg_done_i is seen high during CHARGE, busy_n_o rises at the next edge. plug_en_o then carries the latched selection DELAY_CYC cycles later, for exactly PULSE_CYC cycles. After that, plug_en_o and cap_en_o return to zero.
- R6: If chg_done_i never arrives, busy_n_o stays low for exactly WDOG_CYC cycles. The controller then continues as in R5 and still fires the selected plugs.
- R7: A frame is invalid if it has no bit set, both plugs of one assembly set, or more than two bits set. An invalid frame makes the controller abort. On abort, sel_err_o goes high, busy_n_o stays high and no charge enable is driven. sel_err_o clears at the next frame start.
- R8: If the number of serial clock edges in a frame differs from N_PLUGS, the frame is aborted in the same way as in R7.
- R9: The following inputs have no effect and leave busy_n_o, plug_en_o and the latched selection unchanged:
  - chg_done_i outside CHARGE;
  - fire_i edges outside IDLE and FRAME;
  - sclk_i edges outside FRAME.
- R10: At no time are both plugs of one assembly enabled, more than two plugs enabled, or any plug enabled while busy_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire_i | input | 1 | Synchronised fire line; high frames a selection, falling edge starts charge |
| sclk_i | input | 1 | Synchronised serial clock line |
| sdata_i | input | 1 | Synchronised serial data line |
| chg_done_i | input | 1 | Capacitor voltage reached, from the external comparator |
| busy_n_o | output | 1 | Active-low busy, low while charging |
| plug_en_o | output | N_PLUGS | Spark-plug enable pulses |
| cap_en_o | output | N_PLUGS/2 | Per-capacitor charge enables |
| sel_err_o | output | 1 | Last frame was aborted |

## Verification
The assertions check several rules on every cycle:
- a plug pulse never overlaps busy;
- plugs of one assembly are never paired, and never more than two plugs are enabled;
- an error leaves the charge path idle;
- every busy fall is traced back to a fire fall two edges earlier;
- the timers never wrap.

Other behaviour can only be shown by the bench scenarios, comparing against the cycle model. That covers the reversed mapping, the exact hold-off, pulse and watchdog lengths, the abort cases for bad selections and wrong pulse counts, and the fact that stray inputs in the wrong state have no effect.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_CHARGE,
        ST_HOLDOFF,
        ST_FIRE
    } tfc_state_t;
endpackage

// File: rtl/tfc_edge.sv
// Rising/falling edge detection for a bundle of already-synchronised lines.
module tfc_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        assign rise_o[i] = lvl_i[i] & ~prev_q[i];
        assign fall_o[i] = ~lvl_i[i] & prev_q[i];
    end
endmodule

// File: rtl/tfc_select.sv
// Serial select register, edge counter and selection validity.
module tfc_select #(
    parameter int N_PLUGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 shift_i,
    input  logic                 din_i,
    output logic [N_PLUGS-1:0]   sel_o,
    output logic [N_PLUGS/2-1:0] cap_o,
    output logic                 cnt_ok_o,
    output logic                 sel_ok_o
);
    localparam int NA   = N_PLUGS / 2;
    localparam int CMAX = N_PLUGS + 1;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int OW   = $clog2(N_PLUGS + 1);

    logic [N_PLUGS-1:0] sel_q;
    logic [CW-1:0]      cnt_q;
    logic [NA-1:0]      pair_both;
    logic [OW-1:0]      ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else if (shift_i) begin
            sel_q <= {sel_q[N_PLUGS-2:0], din_i};
            if (cnt_q != CW'(CMAX)) cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar k = 0; k < NA; k++) begin : g_asm
        assign cap_o[k]     = sel_q[2*k] | sel_q[2*k+1];
        assign pair_both[k] = sel_q[2*k] & sel_q[2*k+1];
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < N_PLUGS; i++) ones = ones + OW'(sel_q[i]);
    end

    assign sel_o    = sel_q;
    assign cnt_ok_o = (cnt_q == CW'(N_PLUGS));
    assign sel_ok_o = (ones != '0) && (ones <= OW'(2)) && (pair_both == '0);

    // R2: a frame start leaves an empty selection behind
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sel_o == '0 && !cnt_ok_o));
endmodule

// File: rtl/tfc_timer.sv
// Loadable down counter shared by the watchdog, hold-off and pulse phases.
module tfc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R5/R6: phase timing relies on the counter never wrapping
    a_r5_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/thr_fire_ctl.sv
module thr_fire_ctl
    import tfc_pkg::*;
#(
    parameter int N_PLUGS   = 4,
    parameter int DELAY_CYC = 100000,
    parameter int WDOG_CYC  = 200000000,
    parameter int PULSE_CYC = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire_i,
    input  logic                 sclk_i,
    input  logic                 sdata_i,
    input  logic                 chg_done_i,
    output logic                 busy_n_o,
    output logic [N_PLUGS-1:0]   plug_en_o,
    output logic [N_PLUGS/2-1:0] cap_en_o,
    output logic                 sel_err_o
);
    localparam int NA   = N_PLUGS / 2;
    localparam int M1   = (WDOG_CYC > DELAY_CYC) ? WDOG_CYC : DELAY_CYC;
    localparam int MAXC = (M1 > PULSE_CYC) ? M1 : PULSE_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    tfc_state_t state_q, state_d;
    logic [2:0] rise, fall;
    logic       fire_rise, fire_fall, sclk_rise;
    logic [N_PLUGS-1:0] sel;
    logic [NA-1:0]      cap;
    logic       cnt_ok, sel_ok;
    logic       t_load, t_dec, t_zero, abort;
    logic [TW-1:0] t_val;
    logic       err_q;

    tfc_edge #(.W(3)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({sdata_i, sclk_i, fire_i}),
        .rise_o (rise),
        .fall_o (fall)
    );
    assign fire_rise = rise[0];
    assign fire_fall = fall[0];
    assign sclk_rise = rise[1];

    tfc_select #(.N_PLUGS(N_PLUGS)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state_q == ST_IDLE && fire_rise),
        .shift_i  (state_q == ST_FRAME && sclk_rise),
        .din_i    (sdata_i),
        .sel_o    (sel),
        .cap_o    (cap),
        .cnt_ok_o (cnt_ok),
        .sel_ok_o (sel_ok)
    );

    tfc_timer #(.W(TW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .dec_i      (t_dec),
        .zero_o     (t_zero)
    );

    // state register and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (abort)                                  err_q <= 1'b1;
            else if (state_q == ST_IDLE && fire_rise)   err_q <= 1'b0;
        end
    end

    // next state and timer control
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        t_dec   = 1'b0;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fire_rise) state_d = ST_FRAME;          // start
            end
            ST_FRAME: begin
                if (fire_fall) begin
                    if (cnt_ok && sel_ok) begin             // accept
                        state_d = ST_CHARGE;
                        t_load  = 1'b1;
                        t_val   = TW'(WDOG_CYC - 1);
                    end else begin                          // abort
                        state_d = ST_IDLE;
                        abort   = 1'b1;
                    end
                end
            end
            ST_CHARGE: begin
                if (chg_done_i || t_zero) begin             // charged
                    state_d = ST_HOLDOFF;
                    t_load  = 1'b1;
                    t_val   = TW'(DELAY_CYC - 1);
                end else t_dec = 1'b1;
            end
            ST_HOLDOFF: begin
                if (t_zero) begin                           // spark
                    state_d = ST_FIRE;
                    t_load  = 1'b1;
                    t_val   = TW'(PULSE_CYC - 1);
                end else t_dec = 1'b1;
            end
            ST_FIRE: begin
                if (t_zero) state_d = ST_IDLE;              // done
                else        t_dec   = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        busy_n_o  = (state_q != ST_CHARGE);
        plug_en_o = (state_q == ST_FIRE) ? sel : '0;
        cap_en_o  = (state_q == ST_CHARGE || state_q == ST_HOLDOFF ||
                     state_q == ST_FIRE) ? cap : '0;
        sel_err_o = err_q;
    end

    // R4: busy only falls two edges after fire was seen falling
    a_r4_busy_follows_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n_o) |-> ($past(fire_i) == 1'b0 && $past(fire_i, 2) == 1'b1));

    // R10: no spark while charging, never more than two plugs
    a_r10_no_spark_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n_o |-> (plug_en_o == '0));
    a_r10_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(plug_en_o) <= 2);

    // R5: a spark begins only once busy has already been released
    a_r5_spark_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|plug_en_o) |-> $past(busy_n_o));

    // R7: an aborted frame leaves the charge path idle
    a_r7_err_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err_o |-> (busy_n_o && cap_en_o == '0 && plug_en_o == '0));

    for (genvar k = 0; k < NA; k++) begin : g_pair_chk
        // R10: the two plugs of one assembly never fire together
        a_r10_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(plug_en_o[2*k] && plug_en_o[2*k+1]));
    end
endmodule

// File: tb/thr_fire_ctl_tb.sv
module thr_fire_ctl_tb;
    localparam int N     = 4;
    localparam int NA    = N / 2;
    localparam int DLY   = 20;
    localparam int WDOG  = 300;
    localparam int PULSE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fire = 1'b0, sclk = 1'b0, sdata = 1'b0, done = 1'b0;
    logic          busy_n;
    logic [N-1:0]  plug;
    logic [NA-1:0] cap;
    logic          err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    thr_fire_ctl #(.N_PLUGS(N), .DELAY_CYC(DLY), .WDOG_CYC(WDOG), .PULSE_CYC(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .sclk_i(sclk), .sdata_i(sdata),
        .chg_done_i(done), .busy_n_o(busy_n), .plug_en_o(plug), .cap_en_o(cap),
        .sel_err_o(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int        m_mode;      // 0 idle 1 frame 2 charge 3 holdoff 4 fire
    int        m_elapsed;
    bit        m_err;
    bit        m_fp, m_cp;
    bit        m_q[$];
    logic [N-1:0] m_sel;

    function automatic logic [NA-1:0] cap_of(input logic [N-1:0] s);
        logic [NA-1:0] c;
        for (int k = 0; k < NA; k++) c[k] = s[2*k] | s[2*k+1];
        return c;
    endfunction

    function automatic bit frame_good(input logic [N-1:0] s);
        int n = 0;
        for (int i = 0; i < N; i++) n += s[i];
        for (int k = 0; k < NA; k++) if (s[2*k] && s[2*k+1]) return 1'b0;
        return (n >= 1 && n <= 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_elapsed = 0; m_err = 0; m_fp = 0; m_cp = 0;
            m_sel = '0; m_q.delete();
        end else begin
            case (m_mode)
                0: if (fire && !m_fp) begin m_mode = 1; m_q.delete(); m_err = 0; end
                1: begin
                    if (!fire && m_fp) begin
                        logic [N-1:0] s;
                        s = '0;
                        for (int p = 0; p < m_q.size() && p < N; p++)
                            if (m_q[p]) s[N-1-p] = 1'b1;
                        m_sel = s;
                        if (m_q.size() == N && frame_good(s)) begin
                            m_mode = 2; m_elapsed = 0;
                        end else begin
                            m_mode = 0; m_err = 1;
                        end
                    end else if (sclk && !m_cp) m_q.push_back(sdata);
                end
                2: begin
                    m_elapsed++;
                    if (done || m_elapsed == WDOG) begin m_mode = 3; m_elapsed = 0; end
                end
                3: begin
                    m_elapsed++;
                    if (m_elapsed == DLY) begin m_mode = 4; m_elapsed = 0; end
                end
                default: begin
                    m_elapsed++;
                    if (m_elapsed == PULSE) m_mode = 0;
                end
            endcase
            m_fp = fire; m_cp = sclk;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy_n == (m_mode != 2), "R4/R6 busy vs model", busy_n, (m_mode != 2));
            chk(plug == ((m_mode == 4) ? m_sel : '0), "R5 plug vs model", plug,
                (m_mode == 4) ? m_sel : 0);
            chk(cap == ((m_mode >= 2) ? cap_of(m_sel) : '0), "R3 cap vs model", cap,
                (m_mode >= 2) ? cap_of(m_sel) : 0);
            chk(err == m_err, "R7/R8 err vs model", err, m_err);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bits[p] is the data value at pulse p+1
    task automatic send_frame(input logic [7:0] bits, input int np);
        @(negedge clk) fire = 1'b1;
        wait_n(3);
        for (int p = 0; p < np; p++) begin
            sdata = bits[p];
            wait_n(2);
            sclk = 1'b1;
            wait_n(2);
            sclk = 1'b0;
            wait_n(1);
        end
        sdata = 1'b0;
        wait_n(2);
        fire = 1'b0;
    endtask

    task automatic wait_plug(output int n);
        n = 0;
        while (plug == '0 && n < 1000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        int m;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk(busy_n == 1'b1, "R1 busy after reset", busy_n, 1);
        chk(plug == '0 && cap == '0, "R1 enables after reset", {plug, cap}, 0);
        chk(err == 1'b0, "R1 err after reset", err, 0);

        // R2: serial clock outside a frame is ignored; then single plug 1A
        sclk = 1'b1; wait_n(2); sclk = 1'b0; wait_n(2);
        send_frame(8'b1000, N);
        wait_n(1);
        chk(busy_n == 1'b0, "R4 busy low after fire fall", busy_n, 0);
        chk(cap == 2'b01, "R3 cap for pulse 4", cap, 2'b01);
        wait_n(10);
        done = 1'b1;
        @(negedge clk) done = 1'b0;
        n = 1;
        chk(busy_n == 1'b1, "R5 busy released after done", busy_n, 1);
        while (plug == '0 && n < 1000) begin @(negedge clk); n++; end
        chk(n == DLY + 1, "R5 hold-off length", n, DLY + 1);
        chk(plug == 4'b0001, "R3 pulse 4 maps to plug 1A", plug, 4'b0001);
        m = 0;
        while (plug != '0 && m < 1000) begin m++; @(negedge clk); end
        chk(m == PULSE, "R5 pulse width", m, PULSE);
        chk(cap == '0 && busy_n, "R5 enables cleared after fire", cap, 0);

        // R3: two plugs on different assemblies (pulses 1 and 3)
        wait_n(5);
        send_frame(8'b0101, N);
        wait_n(1);
        chk(cap == 2'b11, "R3 both caps", cap, 2'b11);
        wait_n(5);
        done = 1'b1;
        @(negedge clk) done = 1'b0;
        wait_plug(n);
        chk(plug == 4'b1010, "R3 pulses 1,3 map to 2B,1B", plug, 4'b1010);
        wait_n(PULSE + 3);

        // R6: watchdog fire without charge-done (pulse 2 -> 2A)
        send_frame(8'b0010, N);
        n = 0;
        @(negedge clk);
        while (busy_n == 1'b0 && n < 1000) begin n++; @(negedge clk); end
        chk(n == WDOG, "R6 watchdog busy length", n, WDOG);
        wait_plug(m);
        chk(plug == 4'b0100, "R6 watchdog fires selection", plug, 4'b0100);
        wait_n(PULSE + 3);

        // R7: both plugs of assembly 1 -> abort
        send_frame(8'b1100, N);
        wait_n(1);
        chk(err == 1'b1, "R7 pair selection flagged", err, 1);
        chk(busy_n == 1'b1 && cap == '0, "R7 pair no charge", {busy_n, cap}, 3'b100);
        wait_n(10);
        chk(plug == '0, "R7 pair never fires", plug, 0);
        // R7: empty selection -> abort, err cleared at frame start
        @(negedge clk) fire = 1'b1;
        wait_n(2);
        chk(err == 1'b0, "R7 err cleared at frame start", err, 0);
        fire = 1'b0;
        wait_n(1);
        chk(err == 1'b1, "R8 zero pulses aborts", err, 1);
        send_frame(8'b0000, N);
        wait_n(1);
        chk(err == 1'b1 && busy_n, "R7 empty selection aborts", err, 1);

        // R8: wrong pulse counts
        send_frame(8'b0001, N - 1);
        wait_n(1);
        chk(err == 1'b1 && busy_n, "R8 too few pulses", err, 1);
        send_frame(8'b00001, N + 1);
        wait_n(1);
        chk(err == 1'b1 && busy_n, "R8 too many pulses", err, 1);

        // R9: charge-done in IDLE ignored
        done = 1'b1; wait_n(3); done = 1'b0; wait_n(2);
        chk(busy_n == 1'b1 && plug == '0, "R9 done in idle ignored", plug, 0);
        // R9: fire and serial clock during charge ignored
        send_frame(8'b0100, N);
        wait_n(3);
        fire = 1'b1; sdata = 1'b1; wait_n(2);
        sclk = 1'b1; wait_n(2); sclk = 1'b0; wait_n(2);
        fire = 1'b0; sdata = 1'b0; wait_n(2);
        chk(busy_n == 1'b0, "R9 fire during charge ignored", busy_n, 0);
        done = 1'b1;
        @(negedge clk) done = 1'b0;
        wait_plug(n);
        chk(plug == 4'b0010, "R9 selection unchanged (pulse 3 -> 1B)", plug, 4'b0010);
        chk($countones(plug) <= 2, "R10 at most two plugs", $countones(plug), 1);
        wait_n(PULSE + 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule